// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the receiving front end of a serial flash target. It watches a serial clock, an active-low select and four input lanes, all sampled into the chip's own clock domain. It assembles each incoming frame into bytes. The first byte of a frame is the opcode. Depending on the opcode, address bytes follow, and every later byte is passed on as data. Opcode, address and data appear on a parallel side as single-cycle strobes, and a further strobe marks the end of each frame.

The front end keeps a persistent lane mode. In single-lane mode every bit arrives on lane 0. In four-lane mode every rising serial clock edge carries a nibble, so an opcode takes two edges instead of eight. Dedicated opcodes move the block between the two modes. A two-step software reset, the reset input and power-up all return it to single-lane mode. The idle level of the serial clock may be low or high, which covers both usual clock modes.

Top module: `sqf_front`

## Requirements
- R1: Bits are taken only on a rising serial clock edge while cs_n is low, most significant bit first. In single-lane mode each edge takes one bit from io_in[0], and a byte completes after eight edges.
- R2: In four-lane mode each rising edge takes a nibble from io_in[3:0], with io_in[3] as the most significant bit. Opcode, address and data bytes therefore each complete after two edges.
- R3: Opcode 35h received in single-lane mode sets qpi_mode to 1. Opcode F5h received in four-lane mode clears it. The new mode applies from the next byte on.
- R4: Opcode 35h received in four-lane mode, and F5h received in single-lane mode, leave qpi_mode unchanged.
- R5: If the opcode that directly follows an opcode 66h is 99h, the block pulses soft_rst for one cycle and returns to single-lane mode. The two opcodes may arrive in separate frames.
- R6: Any opcode other than 99h that follows 66h cancels the pending reset enable, so a later 99h has no effect.
- R7: While cs_n is high, serial clock edges and lane values are ignored. A rise of cs_n discards any partial byte, the next frame starts again with a fresh opcode, and each rise of cs_n gives exactly one frame_end pulse.
- R8: After opcode 02h, 03h, 0Bh, 20h, 3Bh, 52h, 5Ah, 62h, 64h, 68h, 6Bh, D7h or D8h, the next ADDR_BYTES bytes form addr, first byte in the top bits. addr_vld pulses once when the last address byte completes, and any bytes after that are data.
- R9: After any other opcode, every later byte of the frame is presented on dat with one dat_vld pulse per byte.
- R10: While rst_n is low, qpi_mode is 0, no strobe is raised and a pending reset enable is cleared.
- R11: A frame decodes the same whether the serial clock idles low or high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset (power-up or hardware) |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| io_in | input | 4 | Serial input lanes; lane 0 only in single-lane mode |
| qpi_mode | output | 1 | 1 when in four-lane mode |
| opc_vld | output | 1 | One-cycle strobe: opcode holds a new opcode |
| opcode | output | 8 | Last received opcode |
| addr_vld | output | 1 | One-cycle strobe: addr is complete |
| addr | output | 8*ADDR_BYTES | Received address |
| dat_vld | output | 1 | One-cycle strobe: dat holds a new data byte |
| dat | output | 8 | Last received data byte |
| frame_end | output | 1 | One-cycle strobe on each rise of cs_n |
| soft_rst | output | 1 | One-cycle strobe when a software reset completes |

## Verification
The bench builds the block with ADDR_BYTES=3 and SYNC=2, and drives a serial clock period of eight chip clocks. With these values, three-byte addresses can be checked in both lane modes, and frames stay short enough to cover every mode transition, including the no-effect cases. The bench also covers a split reset-enable/reset pair, a cancelled reset enable, a frame cut off mid-byte, and clock activity while the block is deselected.

// File: rtl/sqf_front.sv
module sqf_front #(
  parameter int ADDR_BYTES = 3,
  parameter int SYNC       = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic [3:0]              io_in,
  output logic                    qpi_mode,
  output logic                    opc_vld,
  output logic [7:0]              opcode,
  output logic                    addr_vld,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic                    dat_vld,
  output logic [7:0]              dat,
  output logic                    frame_end,
  output logic                    soft_rst
);
  localparam int AW = 8*ADDR_BYTES;
  localparam int CW = $clog2(ADDR_BYTES+1);

  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DATA} phase_t;

  logic [5:0]    pipe [SYNC];
  logic          sck_d, cs_d;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [CW-1:0] acnt;
  logic          armed;
  phase_t        phase;

  wire       sck_s = pipe[SYNC-1][4];
  wire       cs_s  = pipe[SYNC-1][5];
  wire [3:0] io_s  = pipe[SYNC-1][3:0];

  wire       rise    = sck_s & ~sck_d & ~cs_s;
  wire       cs_up   = cs_s & ~cs_d;
  wire [3:0] step    = qpi_mode ? 4'd4 : 4'd1;
  wire [3:0] nxt_cnt = cnt + step;
  wire [7:0] nxt_sh  = qpi_mode ? {sh[3:0], io_s} : {sh[6:0], io_s[0]};
  wire       done    = rise && (nxt_cnt == 4'd8);

  function automatic logic takes_addr(input logic [7:0] op);
    case (op)
      8'h02, 8'h03, 8'h0B, 8'h20, 8'h3B, 8'h52, 8'h5A,
      8'h62, 8'h64, 8'h68, 8'h6B, 8'hD7, 8'hD8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) pipe[i] <= 6'b100000;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      pipe[0] <= {cs_n, sck, io_in};
      for (int i = 1; i < SYNC; i++) pipe[i] <= pipe[i-1];
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      acnt      <= '0;
      armed     <= 1'b0;
      phase     <= PH_OPC;
      qpi_mode  <= 1'b0;
      opc_vld   <= 1'b0;
      opcode    <= '0;
      addr_vld  <= 1'b0;
      addr      <= '0;
      dat_vld   <= 1'b0;
      dat       <= '0;
      frame_end <= 1'b0;
      soft_rst  <= 1'b0;
    end else begin
      opc_vld   <= 1'b0;
      addr_vld  <= 1'b0;
      dat_vld   <= 1'b0;
      soft_rst  <= 1'b0;
      frame_end <= cs_up;
      if (cs_s) begin
        cnt   <= '0;
        acnt  <= '0;
        phase <= PH_OPC;
      end else if (rise) begin
        sh  <= nxt_sh;
        cnt <= done ? 4'd0 : nxt_cnt;
        if (done) begin
          case (phase)
            PH_OPC: begin
              opcode  <= nxt_sh;
              opc_vld <= 1'b1;
              armed   <= (nxt_sh == 8'h66);
              if (armed && nxt_sh == 8'h99) begin
                qpi_mode <= 1'b0;
                soft_rst <= 1'b1;
              end else if (nxt_sh == 8'h35 && !qpi_mode) begin
                qpi_mode <= 1'b1;
              end else if (nxt_sh == 8'hF5 && qpi_mode) begin
                qpi_mode <= 1'b0;
              end
              acnt  <= '0;
              phase <= takes_addr(nxt_sh) ? PH_ADDR : PH_DATA;
            end
            PH_ADDR: begin
              addr <= AW'({addr, nxt_sh});
              acnt <= acnt + 1'b1;
              if (acnt == CW'(ADDR_BYTES-1)) begin
                addr_vld <= 1'b1;
                phase    <= PH_DATA;
              end
            end
            default: begin
              dat     <= nxt_sh;
              dat_vld <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assert_qpi_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_vld && opcode == 8'h35 && !soft_rst) |-> qpi_mode);

  assert_qpi_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_vld && opcode == 8'hF5) |-> !qpi_mode);

  assert_mode_only_on_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qpi_mode) |-> opc_vld);

  assert_soft_reset_spi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!qpi_mode && opc_vld && opcode == 8'h99));

  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> !(opc_vld || addr_vld || dat_vld));

  assert_frame_clears_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (cnt == 4'd0 && phase == PH_OPC));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({opc_vld, addr_vld, dat_vld}));
endmodule

// File: tb/sqf_front_tb.sv
`timescale 1ns/1ps
module sqf_front_tb;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic [3:0] io_in = 4'h0;
  logic qpi_mode, opc_vld, addr_vld, dat_vld, frame_end, soft_rst;
  logic [7:0] opcode, dat;
  logic [23:0] addr;

  always #10 clk = ~clk;

  sqf_front #(.ADDR_BYTES(3), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
    .qpi_mode(qpi_mode), .opc_vld(opc_vld), .opcode(opcode),
    .addr_vld(addr_vld), .addr(addr), .dat_vld(dat_vld), .dat(dat),
    .frame_end(frame_end), .soft_rst(soft_rst));

  int checks = 0;
  int fails = 0;
  int n_opc = 0, n_addr = 0, n_dat = 0, n_fe = 0, n_soft = 0;
  logic [7:0]  opc_log [64];
  logic [7:0]  dat_log [64];
  logic [23:0] last_addr = '0;
  logic [7:0]  fb [8];
  int b_opc, b_addr, b_dat, b_fe, b_soft;

  always @(negedge clk) begin
    if (opc_vld) begin opc_log[n_opc % 64] = opcode; n_opc++; end
    if (addr_vld) begin last_addr = addr; n_addr++; end
    if (dat_vld) begin dat_log[n_dat % 64] = dat; n_dat++; end
    if (frame_end) n_fe++;
    if (soft_rst) n_soft++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mark();
    b_opc = n_opc; b_addr = n_addr; b_dat = n_dat; b_fe = n_fe; b_soft = n_soft;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic edge_with(input logic [3:0] v);
    io_in = v; sck = 1'b0; wait_clk(HP);
    sck = 1'b1; wait_clk(HP);
  endtask

  task automatic send(input int n, input bit q, input bit idle);
    sck = idle; wait_clk(HP);
    cs_n = 1'b0; wait_clk(HP);
    for (int i = 0; i < n; i++) begin
      if (q) begin
        edge_with(fb[i][7:4]);
        edge_with(fb[i][3:0]);
      end else begin
        for (int b = 7; b >= 0; b--) edge_with({3'b000, fb[i][b]});
      end
    end
    sck = idle; wait_clk(HP);
    cs_n = 1'b1; wait_clk(10);
  endtask

  task automatic send1(input logic [7:0] op, input bit q);
    fb[0] = op; send(1, q, 1'b0);
  endtask

  task automatic t_reset();
    chk(qpi_mode == 1'b0, "R10", "qpi after reset", {31'd0, qpi_mode}, 0);
    chk(n_opc + n_addr + n_dat + n_soft == 0, "R10", "strobes in reset",
        n_opc + n_addr + n_dat + n_soft, 0);
  endtask

  task automatic t_spi_read_mode0();
    mark();
    fb[0] = 8'h03; fb[1] = 8'h12; fb[2] = 8'h34; fb[3] = 8'h56;
    fb[4] = 8'hAB; fb[5] = 8'hCD;
    send(6, 1'b0, 1'b0);
    chk(n_opc - b_opc == 1 && opc_log[b_opc % 64] == 8'h03, "R1", "spi opcode",
        opc_log[b_opc % 64], 8'h03);
    chk(n_addr - b_addr == 1 && last_addr == 24'h123456, "R8", "spi address",
        last_addr, 24'h123456);
    chk(n_dat - b_dat == 2 && dat_log[b_dat % 64] == 8'hAB &&
        dat_log[(b_dat+1) % 64] == 8'hCD, "R8", "data after address",
        n_dat - b_dat, 2);
    chk(n_fe - b_fe == 1, "R7", "frame_end count", n_fe - b_fe, 1);
  endtask

  task automatic t_spi_mode3();
    mark();
    fb[0] = 8'h0B; fb[1] = 8'h7F; fb[2] = 8'hF0; fb[3] = 8'h01;
    send(4, 1'b0, 1'b1);
    chk(n_opc - b_opc == 1 && opc_log[b_opc % 64] == 8'h0B, "R11", "mode 3 opcode",
        opc_log[b_opc % 64], 8'h0B);
    chk(n_addr - b_addr == 1 && last_addr == 24'h7FF001, "R11", "mode 3 address",
        last_addr, 24'h7FF001);
  endtask

  task automatic t_no_addr_opcode();
    mark();
    fb[0] = 8'h01; fb[1] = 8'hA5; fb[2] = 8'h5A;
    send(3, 1'b0, 1'b0);
    chk(n_addr - b_addr == 0, "R9", "no address strobe", n_addr - b_addr, 0);
    chk(n_dat - b_dat == 2 && dat_log[b_dat % 64] == 8'hA5 &&
        dat_log[(b_dat+1) % 64] == 8'h5A, "R9", "payload bytes",
        {dat_log[b_dat % 64], dat_log[(b_dat+1) % 64]}, 16'hA55A);
  endtask

  task automatic t_enter_qpi_and_write();
    send1(8'h35, 1'b0);
    chk(qpi_mode == 1'b1, "R3", "enter four-lane", {31'd0, qpi_mode}, 1);
    mark();
    fb[0] = 8'h02; fb[1] = 8'hC0; fb[2] = 8'hFF; fb[3] = 8'hEE; fb[4] = 8'h11;
    send(5, 1'b1, 1'b0);
    chk(n_opc - b_opc == 1 && opc_log[b_opc % 64] == 8'h02, "R2", "nibble opcode",
        opc_log[b_opc % 64], 8'h02);
    chk(last_addr == 24'hC0FFEE && n_addr - b_addr == 1, "R2", "nibble address",
        last_addr, 24'hC0FFEE);
    chk(n_dat - b_dat == 1 && dat_log[b_dat % 64] == 8'h11, "R2", "nibble data",
        dat_log[b_dat % 64], 8'h11);
  endtask

  task automatic t_mode_noops();
    send1(8'h35, 1'b1);
    chk(qpi_mode == 1'b1, "R4", "35h in four-lane keeps mode", {31'd0, qpi_mode}, 1);
    send1(8'hF5, 1'b1);
    chk(qpi_mode == 1'b0, "R3", "F5h leaves four-lane", {31'd0, qpi_mode}, 0);
    send1(8'hF5, 1'b0);
    chk(qpi_mode == 1'b0, "R4", "F5h in single-lane keeps mode", {31'd0, qpi_mode}, 0);
    mark();
    send1(8'h9F, 1'b0);
    chk(opc_log[b_opc % 64] == 8'h9F, "R4", "still single-lane decode",
        opc_log[b_opc % 64], 8'h9F);
  endtask

  task automatic t_soft_reset();
    send1(8'h35, 1'b0);
    mark();
    send1(8'h66, 1'b1);
    chk(n_soft - b_soft == 0 && qpi_mode == 1'b1, "R5", "enable alone",
        n_soft - b_soft, 0);
    send1(8'h99, 1'b1);
    chk(n_soft - b_soft == 1, "R5", "soft reset pulse", n_soft - b_soft, 1);
    chk(qpi_mode == 1'b0, "R5", "mode after soft reset", {31'd0, qpi_mode}, 0);
  endtask

  task automatic t_cancelled_reset();
    send1(8'h35, 1'b0);
    mark();
    send1(8'h66, 1'b1);
    send1(8'h05, 1'b1);
    send1(8'h99, 1'b1);
    chk(n_soft - b_soft == 0, "R6", "cancelled enable", n_soft - b_soft, 0);
    chk(qpi_mode == 1'b1, "R6", "mode kept", {31'd0, qpi_mode}, 1);
    send1(8'hF5, 1'b1);
  endtask

  task automatic t_partial_and_deselected();
    mark();
    sck = 1'b0; cs_n = 1'b0; wait_clk(HP);
    edge_with(4'h1); edge_with(4'h0); edge_with(4'h1);
    sck = 1'b0; wait_clk(HP);
    cs_n = 1'b1; wait_clk(10);
    for (int i = 0; i < 16; i++) edge_with(4'(i));
    sck = 1'b0; wait_clk(10);
    chk(n_opc - b_opc == 0 && n_dat - b_dat == 0, "R7", "no byte from partial or idle",
        n_opc - b_opc, 0);
    chk(n_fe - b_fe == 1, "R7", "one frame_end", n_fe - b_fe, 1);
    send1(8'h9F, 1'b0);
    chk(n_opc - b_opc == 1 && opc_log[b_opc % 64] == 8'h9F, "R7", "fresh opcode",
        opc_log[b_opc % 64], 8'h9F);
  endtask

  task automatic t_hw_reset();
    send1(8'h35, 1'b0);
    chk(qpi_mode == 1'b1, "R3", "four-lane before reset", {31'd0, qpi_mode}, 1);
    send1(8'h66, 1'b1);
    rst_n = 1'b0; wait_clk(4);
    chk(qpi_mode == 1'b0, "R10", "hw reset clears mode", {31'd0, qpi_mode}, 0);
    rst_n = 1'b1; wait_clk(4);
    mark();
    send1(8'h99, 1'b0);
    chk(n_soft - b_soft == 0, "R10", "enable cleared by reset", n_soft - b_soft, 0);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_spi_read_mode0();
    t_spi_mode3();
    t_no_addr_opcode();
    t_enter_qpi_and_write();
    t_mode_noops();
    t_soft_reset();
    t_cancelled_reset();
    t_partial_and_deselected();
    t_hw_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule